// File: doc/BRIEF.md
# Forwarding Two-Stage Add Pipeline

This block is a small integer datapath that executes register-to-register additions through two concurrent stages. Each incoming operation names a destination register and two source registers; its architectural effect is that the destination receives the sum of the two sources, wrapping modulo 2^DW. The execute stage reads both sources and computes the sum into an execute register, and the write-back stage commits the result held there into the register file on the next clock edge. Both stages act on the same clock edge. At that edge the older operation retires while the newer one enters execute.

Because the newer operation reads the file before the older one has written it, the block compares the execute operation's destination against both sources of the incoming operation in the same cycle. On a match it takes the pending execute result in place of the stale file value. No stall is ever needed, and one operation can be accepted on every clock. A debug port reads any register combinationally. The same port can also load a register, which the test environment uses to seed values into a file that otherwise resets to zero.

Top module: `fwd_add_top`

## Requirements
- R1: After reset every register reads zero through the debug port and `exValid` is 0.
- R2: An accepted operation's destination register holds (srcA + srcB) mod 2^DW one clock edge after the operation leaves execute, visible on `dbgRdData` when `dbgIdx` selects it.
- R3: An operation presented with `opValid`=1 before a rising edge is held in execute after that edge: `exValid`=1, `exDst` equals its destination, and `exResult` is its sum.
- R4: When the execute destination matches neither source of the incoming operation, both operands come from the register file.
- R5: When the execute destination equals the incoming source A but not source B, the new sum is the pending `exResult` plus register[source B].
- R6: When the execute destination equals source B, or both sources, every matching operand takes the pending `exResult`.
- R7: Operations are accepted on consecutive cycles with no stall, and the architectural state after any sequence equals in-order sequential execution.
- R8: A cycle with `opValid`=0 commits the held result and leaves `exValid`=0 after the edge.
- R9: Whenever `exValid`=1, `exResult` equals the sum of the execute operation's two sources as held in the register file after the same edge.
- R10: With `dbgWrEn`=1, register[`dbgIdx`] takes `dbgWrData` at the edge. If write-back targets the same register in that cycle, write-back wins. A debug write is not forwarded to an operation entering execute in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opDst | input | IDXW | Destination register index |
| opSrcA | input | IDXW | First source register index |
| opSrcB | input | IDXW | Second source register index |
| dbgWrEn | input | 1 | Debug write strobe |
| dbgIdx | input | IDXW | Debug register index for read and write |
| dbgWrData | input | DW | Debug write value |
| dbgRdData | output | DW | Register file contents at `dbgIdx` |
| exValid | output | 1 | Execute register holds an operation |
| exDst | output | IDXW | Destination of the operation in execute |
| exResult | output | DW | Sum held in execute |

## Verification
The bench builds the block with the default 8 registers of 32 bits. With only eight indices, randomly drawn operations hit a source-A, source-B or double match against the operation in execute in a large share of cycles. Seeded full-width operands make the modulo-2^32 wrap occur often, and a directed case also forces it. Each accepted operation's `exResult` is compared against an in-order reference file. Idle cycles followed by full dumps through the debug port confirm that the committed file matches sequential execution.

// File: rtl/fwd_add_pkg.sv
package fwd_add_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic wbEn;    // commit execute result into the file
    logic exLoad;  // capture incoming op into execute
    logic fwdA;    // operand A takes pending execute result
    logic fwdB;    // operand B takes pending execute result
    logic dbgWr;   // debug write allowed this cycle
  } fwd_ctl_t;

endpackage

// File: rtl/fwd_add_ctrl.sv
module fwd_add_ctrl
  import fwd_add_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [IDXW-1:0] opSrcA,
  input  logic [IDXW-1:0] opSrcB,
  input  logic [IDXW-1:0] exDst,
  input  logic            dbgWrEn,
  input  logic [IDXW-1:0] dbgIdx,
  output fwd_ctl_t        ctl,
  output logic            exValid
);

  logic hitA;
  logic hitB;
  logic dbgClash;

  // Same-cycle hazard compare against the op sitting in execute
  assign hitA     = exValid && (exDst == opSrcA);
  assign hitB     = exValid && (exDst == opSrcB);
  assign dbgClash = exValid && (exDst == dbgIdx);

  always_comb begin
    ctl        = '0;
    ctl.wbEn   = exValid;
    ctl.exLoad = opValid;
    ctl.fwdA   = hitA;
    ctl.fwdB   = hitB;
    ctl.dbgWr  = dbgWrEn && !dbgClash;
  end

  // Execute occupancy: filled by an incoming op, drained by an idle cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) exValid <= 1'b0;
    else       exValid <= opValid;
  end

endmodule

// File: rtl/fwd_add_dp.sv
module fwd_add_dp
  import fwd_add_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(NREGS),
  localparam int NOPS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  fwd_ctl_t        ctl,
  input  logic [IDXW-1:0] opDst,
  input  logic [IDXW-1:0] opSrcA,
  input  logic [IDXW-1:0] opSrcB,
  input  logic [IDXW-1:0] dbgIdx,
  input  logic [DW-1:0]   dbgWrData,
  output logic [DW-1:0]   dbgRdData,
  output logic [IDXW-1:0] exDst,
  output logic [DW-1:0]   exResult
);

  logic [DW-1:0]   regFile [NREGS];
  logic [IDXW-1:0] srcIdx  [NOPS];
  logic [NOPS-1:0] fwdSel;
  logic [DW-1:0]   operand [NOPS];
  logic [DW-1:0]   sumNext;

  assign srcIdx[0] = opSrcA;
  assign srcIdx[1] = opSrcB;
  assign fwdSel    = {ctl.fwdB, ctl.fwdA};

  // One read port per operand, each with its own bypass mux
  for (genvar p = 0; p < NOPS; p++) begin : g_operand
    always_comb begin
      if (fwdSel[p]) operand[p] = exResult;
      else           operand[p] = regFile[srcIdx[p]];
    end
  end

  assign sumNext   = operand[0] + operand[1];
  assign dbgRdData = regFile[dbgIdx];

  // Register file: write-back is applied after debug write so it wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regFile[i] <= '0;
    end else begin
      if (ctl.dbgWr) regFile[dbgIdx] <= dbgWrData;
      if (ctl.wbEn)  regFile[exDst]  <= exResult;
    end
  end

  // Execute pipeline register: op destination and ALU result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exDst    <= '0;
      exResult <= '0;
    end else if (ctl.exLoad) begin
      exDst    <= opDst;
      exResult <= sumNext;
    end
  end

endmodule

// File: rtl/fwd_add_top.sv
module fwd_add_top
  import fwd_add_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [IDXW-1:0] opDst,
  input  logic [IDXW-1:0] opSrcA,
  input  logic [IDXW-1:0] opSrcB,
  input  logic            dbgWrEn,
  input  logic [IDXW-1:0] dbgIdx,
  input  logic [DW-1:0]   dbgWrData,
  output logic [DW-1:0]   dbgRdData,
  output logic            exValid,
  output logic [IDXW-1:0] exDst,
  output logic [DW-1:0]   exResult
);

  fwd_ctl_t ctl;

  fwd_add_ctrl #(.NREGS(NREGS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opSrcA  (opSrcA),
    .opSrcB  (opSrcB),
    .exDst   (exDst),
    .dbgWrEn (dbgWrEn),
    .dbgIdx  (dbgIdx),
    .ctl     (ctl),
    .exValid (exValid)
  );

  fwd_add_dp #(.NREGS(NREGS), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opDst     (opDst),
    .opSrcA    (opSrcA),
    .opSrcB    (opSrcB),
    .dbgIdx    (dbgIdx),
    .dbgWrData (dbgWrData),
    .dbgRdData (dbgRdData),
    .exDst     (exDst),
    .exResult  (exResult)
  );

endmodule

// File: rtl/fwd_add_chk.sv
module fwd_add_chk #(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(NREGS)
) (
  input logic            clk,
  input logic            rstN,
  input logic            opValid,
  input logic [IDXW-1:0] opDst,
  input logic [IDXW-1:0] opSrcA,
  input logic [IDXW-1:0] opSrcB,
  input logic            dbgWrEn,
  input logic [IDXW-1:0] dbgIdx,
  input logic [DW-1:0]   dbgWrData,
  input logic [DW-1:0]   dbgRdData,
  input logic            exValid,
  input logic [IDXW-1:0] exDst,
  input logic [DW-1:0]   exResult
);

  // Shadow file rebuilt from the block's own outputs and debug writes
  logic [DW-1:0]   shadow [NREGS];
  logic [IDXW-1:0] heldA;
  logic [IDXW-1:0] heldB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) shadow[i] <= '0;
      heldA <= '0;
      heldB <= '0;
    end else begin
      if (dbgWrEn) shadow[dbgIdx] <= dbgWrData;
      if (exValid) shadow[exDst]  <= exResult;
      if (opValid) begin
        heldA <= opSrcA;
        heldB <= opSrcB;
      end
    end
  end

  // R3: an accepted op occupies execute after the edge
  assert_exec_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (exValid && exDst == $past(opDst)));

  // R8: an idle cycle empties execute
  assert_idle_drain_R8: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !exValid);

  // R2: the retiring result lands in its destination register
  assert_writeback_R2: assert property (@(posedge clk) disable iff (!rstN)
    exValid |=> ((dbgIdx != $past(exDst)) || (dbgRdData == $past(exResult))));

  // R9: execute result agrees with the architectural file
  assert_result_glue_R9: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> (exResult == shadow[heldA] + shadow[heldB]));

  // R10: debug write lands when no write-back is pending
  assert_debug_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWrEn && !exValid) |=> ((dbgIdx != $past(dbgIdx)) || (dbgRdData == $past(dbgWrData))));

endmodule

bind fwd_add_top fwd_add_chk #(.NREGS(NREGS), .DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opDst     (opDst),
  .opSrcA    (opSrcA),
  .opSrcB    (opSrcB),
  .dbgWrEn   (dbgWrEn),
  .dbgIdx    (dbgIdx),
  .dbgWrData (dbgWrData),
  .dbgRdData (dbgRdData),
  .exValid   (exValid),
  .exDst     (exDst),
  .exResult  (exResult)
);

// File: tb/fwd_add_top_tb.sv
`timescale 1ns/1ps
module fwd_add_top_tb;

  localparam int NREGS = 8;
  localparam int DW    = 32;
  localparam int IDXW  = $clog2(NREGS);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            opValid = 1'b0;
  logic [IDXW-1:0] opDst = '0;
  logic [IDXW-1:0] opSrcA = '0;
  logic [IDXW-1:0] opSrcB = '0;
  logic            dbgWrEn = 1'b0;
  logic [IDXW-1:0] dbgIdx = '0;
  logic [DW-1:0]   dbgWrData = '0;
  logic [DW-1:0]   dbgRdData;
  logic            exValid;
  logic [IDXW-1:0] exDst;
  logic [DW-1:0]   exResult;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] refFile [NREGS];

  always #10 clk = ~clk;  // 50 MHz

  fwd_add_top #(.NREGS(NREGS), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opDst(opDst),
    .opSrcA(opSrcA), .opSrcB(opSrcB), .dbgWrEn(dbgWrEn), .dbgIdx(dbgIdx),
    .dbgWrData(dbgWrData), .dbgRdData(dbgRdData), .exValid(exValid),
    .exDst(exDst), .exResult(exResult)
  );

  function automatic logic [DW-1:0] refSum(input logic [IDXW-1:0] a, input logic [IDXW-1:0] b);
    return refFile[a] + refFile[b];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one op at a negedge, sample execute at the next negedge
  task automatic issue(input string tag, input logic [IDXW-1:0] d,
                       input logic [IDXW-1:0] a, input logic [IDXW-1:0] b);
    logic [DW-1:0] exp;
    exp = refSum(a, b);
    refFile[d] = exp;
    opValid = 1'b1; opDst = d; opSrcA = a; opSrcB = b;
    @(negedge clk);
    check({tag, " R3 valid"}, {31'd0, exValid}, 32'd1);
    check({tag, " R3 dst"}, {{(DW-IDXW){1'b0}}, exDst}, {{(DW-IDXW){1'b0}}, d});
    check({tag, " R9 result"}, exResult, exp);
  endtask

  task automatic idle(input string tag);
    opValid = 1'b0;
    @(negedge clk);
    check({tag, " R8 drained"}, {31'd0, exValid}, 32'd0);
  endtask

  task automatic dump(input string tag);
    idle(tag);
    for (int i = 0; i < NREGS; i++) begin
      dbgIdx = i[IDXW-1:0];
      #1;
      check($sformatf("%s R2 R7 reg%0d", tag, i), dbgRdData, refFile[i]);
    end
  endtask

  task automatic load(input logic [IDXW-1:0] idx, input logic [DW-1:0] val);
    dbgWrEn = 1'b1; dbgIdx = idx; dbgWrData = val;
    refFile[idx] = val;
    @(negedge clk);
    dbgWrEn = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREGS; i++) refFile[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 exValid", {31'd0, exValid}, 32'd0);
    dump("R1 reset");

    // R10: seed the file through the debug port
    for (int i = 0; i < NREGS; i++) load(i[IDXW-1:0], $urandom);
    load(3'd1, 32'hFFFF_FFFF);
    load(3'd2, 32'h0000_0002);
    dump("R10 seed");

    // R4: independent op, R2 wrap modulo 2^32
    issue("R4 R2 wrap", 3'd3, 3'd1, 3'd2);
    issue("R4 nohazard", 3'd5, 3'd6, 3'd7);
    // R5: source A matches pending destination
    issue("R5 fwdA", 3'd4, 3'd5, 3'd2);
    // R6: source B matches
    issue("R6 fwdB", 3'd6, 3'd7, 3'd4);
    // R6: both sources match
    issue("R6 fwdAB", 3'd6, 3'd6, 3'd6);
    // R5: self-dependency chain
    issue("R5 chain", 3'd6, 3'd6, 3'd0);
    dump("R7 directed");

    // R10: debug write collides with write-back on the same register
    issue("R10 pre", 3'd2, 3'd0, 3'd1);
    opValid = 1'b0;
    dbgWrEn = 1'b1; dbgIdx = 3'd2; dbgWrData = 32'hDEAD_BEEF;
    @(negedge clk);
    dbgWrEn = 1'b0;
    #1;
    check("R10 wb wins", dbgRdData, refFile[2]);
    dump("R10 collide");

    // R7: random back-to-back streams with idle gaps
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 5 == 0) idle("R8 rand");
      else issue("R7 rand", IDXW'($urandom), IDXW'($urandom), IDXW'($urandom));
      if (n % 60 == 59) dump("R7 rand");
    end
    dump("R7 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule